// File: doc/BRIEF.md
# Scan-Programmed Clock Phase Distributor

This block produces per-cycle enables for four groups of clock outputs, all running from one master clock that is eight times faster than the system cycle. A three-bit phase counter steps once per master edge and returns to zero when a once-per-cycle reference tick is sampled. Each group can be switched on or off, and when on it is active during exactly one of the eight phase slots. That slot is chosen by software through a serial scan interface.

The scan interface is made up of three shift rings, and a select input picks the active one. The phase ring drives the group settings directly. The control ring is shifted in first and takes effect only when a load strobe copies it into working registers. The working registers hold a temperature threshold and a one-shot trip-clear bit. The status ring is captured from internal state in one cycle and then shifted out. Each ring shifts toward bit 0 and takes new data at its top bit, and its bit 0 drives the scan output. The output feeds the next instance in a daisy chain.

A digital temperature code is compared against the loaded threshold. When the code is strictly greater, a trip flag is set. The flag stays set until a load with the clear bit removes it.

Top module: `clkPhaseDist`

## Requirements
- R1: The phase counter is 0 in the cycle after an edge at which refTick is high. At every other master edge it advances by one modulo 8, so it wraps from 7 to 0 without a reference.
- R2: groupEn[g] is high exactly when phase-ring bit 4g+3 (enable) is 1 and phase-ring bits 4g+2..4g (phase index) equal the phase counter. Group 0 uses the lowest nibble.
- R3: With ringSel=0 and scanShift=1, the 16-bit phase ring shifts right one bit per edge, taking scanIn at bit 15. While ringSel=0, scanOut shows ring bit 0, so a value shifted in LSB first reappears on scanOut in the same order.
- R4: With ringSel=1 and scanShift=1, the 14-bit control ring shifts the same way. The threshold (control bits 7..0) takes effect only on an edge where scanLoad is high.
- R5: With ringSel=2 and scanShift=1, the 47-bit status ring shifts and scanOut shows its bit 0. A scanCapture edge loads the status ring with: phase ring at bits 15..0, threshold at 23..16, tempCode at 31..24, trip flag at 32, control-ring bits 13..9 at 37..33, and zeros above.
- R6: The trip flag is set on an edge where tempCode is strictly greater than the threshold, and it stays set after tempCode falls. An equal code does not set it.
- R7: A load edge with control-ring bit 8 set clears the trip flag. The clear wins over a set on that same edge.
- R8: After reset all rings are zero, the threshold is all ones, the counter is 0, and groupEn, tempTrip and scanOut are 0.
- R9: scanCapture takes priority over a shift of the status ring on the same edge. With ringSel=3, no ring shifts and scanOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, eight edges per system cycle |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference tick marking the cycle boundary |
| scanShift | input | 1 | Shift the selected ring one bit |
| scanCapture | input | 1 | Capture internal state into the status ring |
| scanLoad | input | 1 | Copy the control ring into working registers |
| ringSel | input | 2 | Ring select: 0 phase, 1 control, 2 status, 3 none |
| scanIn | input | 1 | Serial data from the previous chain element |
| tempCode | input | 8 | Measured temperature code |
| scanOut | output | 1 | Serial data to the next chain element |
| groupEn | output | 4 | Per-group clock enables |
| tempTrip | output | 1 | Latched over-temperature flag |

## Verification
The bench uses the default parameters: four groups, three-bit phases, an 8-bit temperature code, and rings of 16, 14 and 47 bits. These values make every phase slot and every group reachable within eight-cycle windows. The full status ring, including the reserved control bits, can be read back end to end. The threshold can be set both equal to and just below the temperature code, so the strict compare and the clear-versus-set race can both be observed.

// File: rtl/clkPhasePkg.sv
package clkPhasePkg;
  typedef struct packed {
    logic       shiftPhase;
    logic       shiftCtrl;
    logic       shiftStat;
    logic       capStat;
    logic       loadCtrl;
    logic [1:0] outSel;
  } scanStb_t;

  localparam logic [1:0] SEL_PHASE = 2'd0;
  localparam logic [1:0] SEL_CTRL  = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;
endpackage

// File: rtl/clkPhaseCtrl.sv
module clkPhaseCtrl
  import clkPhasePkg::*;
(
  input  logic       scanShift,
  input  logic       scanCapture,
  input  logic       scanLoad,
  input  logic [1:0] ringSel,
  output scanStb_t   stb
);
  always_comb begin
    stb.shiftPhase = scanShift && (ringSel == SEL_PHASE);
    stb.shiftCtrl  = scanShift && (ringSel == SEL_CTRL);
    // capture has priority over shifting the status ring
    stb.shiftStat  = scanShift && (ringSel == SEL_STAT) && !scanCapture;
    stb.capStat    = scanCapture;
    stb.loadCtrl   = scanLoad;
    stb.outSel     = ringSel;
  end
endmodule

// File: rtl/clkPhaseDp.sv
module clkPhaseDp
  import clkPhasePkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int PHASE_W = 3,
  parameter int TEMP_W  = 8,
  parameter int CTRL_W  = 14,
  parameter int STAT_W  = 47,
  localparam int FIELD_W = PHASE_W + 1,
  localparam int PRING_W = GROUPS * FIELD_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  scanStb_t           stb,
  input  logic               scanIn,
  input  logic               refTick,
  input  logic [TEMP_W-1:0]  tempCode,
  output logic               scanOut,
  output logic [GROUPS-1:0]  groupEn,
  output logic               tempTrip,
  output logic [PHASE_W-1:0] phaseCount,
  output logic [PRING_W-1:0] phaseRing,
  output logic [CTRL_W-1:0]  ctrlRing
);
  localparam int CLR_BIT = TEMP_W;
  localparam int RSV_W   = CTRL_W - TEMP_W - 1;
  localparam int CAP_W   = RSV_W + 1 + 2 * TEMP_W + PRING_W;

  logic [TEMP_W-1:0] threshold;
  logic [STAT_W-1:0] statRing;
  logic [STAT_W-1:0] statCap;
  logic              tripClr;
  logic              overTemp;

  always_ff @(posedge clk) begin
    if (!rstN) phaseCount <= '0;
    else if (refTick) phaseCount <= '0;
    else phaseCount <= phaseCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) phaseRing <= '0;
    else if (stb.shiftPhase) phaseRing <= {scanIn, phaseRing[PRING_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctrlRing <= '0;
    else if (stb.shiftCtrl) ctrlRing <= {scanIn, ctrlRing[CTRL_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) threshold <= '1;
    else if (stb.loadCtrl) threshold <= ctrlRing[TEMP_W-1:0];
  end

  always_comb begin
    statCap = '0;
    statCap[CAP_W-1:0] = {ctrlRing[CTRL_W-1:CLR_BIT+1], tempTrip, tempCode,
                          threshold, phaseRing};
  end

  always_ff @(posedge clk) begin
    if (!rstN) statRing <= '0;
    else if (stb.capStat) statRing <= statCap;
    else if (stb.shiftStat) statRing <= {scanIn, statRing[STAT_W-1:1]};
  end

  assign tripClr  = stb.loadCtrl && ctrlRing[CLR_BIT];
  assign overTemp = tempCode > threshold;

  always_ff @(posedge clk) begin
    if (!rstN) tempTrip <= 1'b0;
    else if (tripClr) tempTrip <= 1'b0;
    else if (overTemp) tempTrip <= 1'b1;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    assign groupEn[g] = phaseRing[g*FIELD_W + PHASE_W] &&
                        (phaseRing[g*FIELD_W +: PHASE_W] == phaseCount);
  end

  always_comb begin
    case (stb.outSel)
      SEL_PHASE: scanOut = phaseRing[0];
      SEL_CTRL:  scanOut = ctrlRing[0];
      SEL_STAT:  scanOut = statRing[0];
      default:   scanOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/clkPhaseDist.sv
module clkPhaseDist
  import clkPhasePkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int PHASE_W = 3,
  parameter int TEMP_W  = 8,
  parameter int CTRL_W  = 14,
  parameter int STAT_W  = 47,
  localparam int PRING_W = GROUPS * (PHASE_W + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              scanShift,
  input  logic              scanCapture,
  input  logic              scanLoad,
  input  logic [1:0]        ringSel,
  input  logic              scanIn,
  input  logic [TEMP_W-1:0] tempCode,
  output logic              scanOut,
  output logic [GROUPS-1:0] groupEn,
  output logic              tempTrip
);
  scanStb_t           stb;
  logic [PHASE_W-1:0] phaseCount;
  logic [PRING_W-1:0] phaseRing;
  logic [CTRL_W-1:0]  ctrlRing;

  clkPhaseCtrl u_ctrl (
    .scanShift(scanShift), .scanCapture(scanCapture), .scanLoad(scanLoad),
    .ringSel(ringSel), .stb(stb)
  );

  clkPhaseDp #(
    .GROUPS(GROUPS), .PHASE_W(PHASE_W), .TEMP_W(TEMP_W),
    .CTRL_W(CTRL_W), .STAT_W(STAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .scanIn(scanIn), .refTick(refTick),
    .tempCode(tempCode), .scanOut(scanOut), .groupEn(groupEn),
    .tempTrip(tempTrip), .phaseCount(phaseCount), .phaseRing(phaseRing),
    .ctrlRing(ctrlRing)
  );
endmodule

// File: rtl/clkPhaseDistChk.sv
module clkPhaseDistChk #(
  parameter int GROUPS  = 4,
  parameter int PHASE_W = 3,
  parameter int TEMP_W  = 8,
  parameter int CTRL_W  = 14,
  localparam int FIELD_W = PHASE_W + 1,
  localparam int PRING_W = GROUPS * FIELD_W
)(
  input logic               clk,
  input logic               rstN,
  input logic               refTick,
  input logic               scanLoad,
  input logic [1:0]         ringSel,
  input logic               scanOut,
  input logic [GROUPS-1:0]  groupEn,
  input logic               tempTrip,
  input logic [PHASE_W-1:0] phaseCount,
  input logic [PRING_W-1:0] phaseRing,
  input logic [CTRL_W-1:0]  ctrlRing
);
  a_r1_ref_zero: assert property (@(posedge clk) disable iff (!rstN)
    refTick |=> (phaseCount == '0));

  a_r1_advance: assert property (@(posedge clk) disable iff (!rstN)
    !refTick |=> (phaseCount == PHASE_W'($past(phaseCount) + 1'b1)));

  a_r6_trip_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (tempTrip && !scanLoad) |=> tempTrip);

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (scanLoad && ctrlRing[TEMP_W]) |=> !tempTrip);

  a_r9_idle_out: assert property (@(posedge clk) disable iff (!rstN)
    (ringSel == 2'd3) |-> !scanOut);

  for (genvar g = 0; g < GROUPS; g++) begin : gChk
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !phaseRing[g*FIELD_W + PHASE_W] |-> !groupEn[g]);
  end
endmodule

bind clkPhaseDist clkPhaseDistChk #(
  .GROUPS(GROUPS), .PHASE_W(PHASE_W), .TEMP_W(TEMP_W), .CTRL_W(CTRL_W)
) chk (
  .clk(clk), .rstN(rstN), .refTick(refTick), .scanLoad(scanLoad),
  .ringSel(ringSel), .scanOut(scanOut), .groupEn(groupEn),
  .tempTrip(tempTrip), .phaseCount(phaseCount), .phaseRing(phaseRing),
  .ctrlRing(ctrlRing)
);

// File: tb/clkPhaseDist_test.sv
module clkPhaseDist_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       refTick, scanShift, scanCapture, scanLoad, scanIn;
  logic [1:0] ringSel;
  logic [7:0] tempCode;
  logic       scanOut, tempTrip;
  logic [3:0] groupEn;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkPhaseDist uut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .scanShift(scanShift),
    .scanCapture(scanCapture), .scanLoad(scanLoad), .ringSel(ringSel),
    .scanIn(scanIn), .tempCode(tempCode), .scanOut(scanOut),
    .groupEn(groupEn), .tempTrip(tempTrip)
  );

  function automatic logic [3:0] expGroups(input logic [15:0] ring, input int cnt);
    logic [3:0] r;
    for (int g = 0; g < 4; g++)
      r[g] = ring[4*g+3] && (int'(ring[4*g +: 3]) == cnt);
    return r;
  endfunction

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic shiftRing(input logic [1:0] sel, input logic [63:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      ringSel = sel; scanShift = 1'b1; scanIn = val[i];
      cyc();
    end
    scanShift = 1'b0; scanIn = 1'b0;
  endtask

  task automatic loadCtrl();
    scanLoad = 1'b1; cyc(); scanLoad = 1'b0;
  endtask

  task automatic readStatus(output logic [46:0] got, input logic withShift);
    scanCapture = 1'b1; ringSel = 2'd2; scanShift = withShift; scanIn = 1'b1;
    cyc();
    scanCapture = 1'b0; scanShift = 1'b0; scanIn = 1'b0;
    for (int i = 0; i < 47; i++) begin
      got[i] = scanOut;
      scanShift = 1'b1;
      cyc();
    end
    scanShift = 1'b0;
  endtask

  // reference tick, then compare eight slots and a wrapped second pass
  task automatic checkPhases(input logic [15:0] ring);
    refTick = 1'b1; cyc(); refTick = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(64'(groupEn), 64'(expGroups(ring, k)), "R2 group enable vs phase slot (R1 count)");
      cyc();
    end
    for (int k = 0; k < 8; k++) begin
      check(64'(groupEn), 64'(expGroups(ring, k)), "R1 wrap without reference");
      cyc();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] ring;
    logic [46:0] stat;
    logic [46:0] expStat;
    logic [13:0] ctrl;
    void'($urandom(32'd4711));
    rstN = 1'b0; refTick = 1'b0; scanShift = 1'b0; scanCapture = 1'b0;
    scanLoad = 1'b0; scanIn = 1'b0; ringSel = 2'd0; tempCode = 8'd100;
    repeat (3) cyc();
    check(64'(groupEn), 64'h0, "R8 reset groupEn");
    check(64'(tempTrip), 64'h0, "R8 reset tempTrip");
    check(64'(scanOut), 64'h0, "R8 reset scanOut");
    rstN = 1'b1;
    repeat (4) cyc();
    check(64'(tempTrip), 64'h0, "R8 threshold all ones after reset");

    // R2/R3 directed and random phase settings
    for (int t = 0; t < 8; t++) begin
      case (t)
        0: ring = 16'h8888;
        1: ring = 16'h7654;
        2: ring = 16'hFDB9;
        3: ring = 16'hCCCC;
        default: ring = 16'($urandom());
      endcase
      shiftRing(2'd0, 64'(ring), 16);
      checkPhases(ring);
    end

    // R3 chain forwarding: shifted value reappears on scanOut
    ring = 16'hA5C3;
    shiftRing(2'd0, 64'(ring), 16);
    for (int i = 0; i < 16; i++) begin
      check(64'(scanOut), 64'(ring[i]), "R3 phase ring forward to chain");
      ringSel = 2'd0; scanShift = 1'b1; scanIn = ring[i];
      cyc();
    end
    scanShift = 1'b0;

    // R9 sel 3: no shift, scanOut 0
    ringSel = 2'd3; cyc();
    check(64'(scanOut), 64'h0, "R9 idle select scanOut");
    shiftRing(2'd3, 64'hFFFF, 16);
    checkPhases(ring);

    // R4 control ring shifted but not loaded
    tempCode = 8'd100;
    ctrl = {5'b10110, 1'b0, 8'd50};
    shiftRing(2'd1, 64'(ctrl), 14);
    repeat (3) cyc();
    check(64'(tempTrip), 64'h0, "R4 threshold idle until load");
    checkPhases(ring);
    loadCtrl();
    cyc();
    check(64'(tempTrip), 64'h1, "R6 trip when code above threshold");
    tempCode = 8'd10;
    repeat (3) cyc();
    check(64'(tempTrip), 64'h1, "R6 trip latched after cooling");

    // R5 status capture and readout
    readStatus(stat, 1'b0);
    expStat = {9'b0, ctrl[13:9], 1'b1, 8'd10, 8'd50, ring};
    check(64'(stat), 64'(expStat), "R5 status ring contents");
    readStatus(stat, 1'b1);
    check(64'(stat), 64'(expStat), "R9 capture beats shift");

    // R7 clear, then R6 equality and strict compare
    ctrl = {5'b00011, 1'b1, 8'd10};
    shiftRing(2'd1, 64'(ctrl), 14);
    loadCtrl();
    check(64'(tempTrip), 64'h0, "R7 clear by load");
    repeat (3) cyc();
    check(64'(tempTrip), 64'h0, "R6 equal code does not trip");
    tempCode = 8'd11; cyc();
    check(64'(tempTrip), 64'h1, "R6 one above threshold trips");
    loadCtrl();
    check(64'(tempTrip), 64'h0, "R7 clear wins over set");
    cyc();
    check(64'(tempTrip), 64'h1, "R6 re-trip after clear while hot");

    // random temperature sweep against threshold 10
    tempCode = 8'd0;
    loadCtrl(); cyc();
    for (int i = 0; i < 20; i++) begin
      logic [7:0] tc;
      tc = 8'($urandom_range(0, 20));
      tempCode = tc; cyc();
      check(64'(tempTrip), 64'(tc > 8'd10), "R6 random compare");
      tempCode = 8'd0;
      loadCtrl(); cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule